// File: doc/BRIEF.md
# Flash Program/Erase Control Register

This block is the 16-bit control and status register that a CPU uses to launch self-timed program and erase operations on an on-chip non-volatile array. Software writes an operation code, an erase/program mode bit and a write-enable bit. It then sets the start bit. The block checks the request and either issues a one-cycle command strobe to the array or rejects the request and sets a sticky error flag.

The start bit can only be set by software, and only the block clears it. It clears the bit when the array reports completion, when the array aborts a busy operation, or when the request is rejected. While an operation is running, the configuration fields are frozen. All register state is cleared only by the power-on reset input.

Top module: `flash_nvm_ctl`

## Requirements
- R1: The read value places start at bit 15, write enable at bit 14, error flag at bit 13, erase mode at bit 6 and the operation code at bits 3:0. All other bits read 0 and ignore writes. Software writes cannot change the error flag.
- R2: A low level on `por_n` at a clock edge clears every register field to 0 and drops the command strobe. The read value is 0x0000 afterwards.
- R3: A start with enable set is accepted for these code/mode pairs, and `cmd_op` carries the listed value: 0011 with mode 0 gives word program (0); 0001 with mode 0 gives row program (1); 0010 with mode 1 gives page erase (2); 1111 with mode 1 and `prog_mode_i` high gives bulk erase (3).
- R4: Code 1111 with mode 1 is rejected while `prog_mode_i` is low.
- R5: A start written while the enable bit in the same write is 0 is rejected. Start reads 1 for the one cycle after the write and then reads 0 with the error flag set, and `cmd_start` stays low.
- R6: A start with a valid code paired with the wrong mode, or with any other code value, is rejected in the same way as in R5.
- R7: An accepted start drives `cmd_start` high for exactly one cycle, in the second cycle after the write edge. The same edge clears the error flag.
- R8: The start bit stays 1 until the edge at which `arr_done_i` is high. Writing 0 to bit 15 has no effect. That edge clears the bit and leaves the error flag at 0.
- R9: While start is 1, writes to bit 15, the enable bit, the mode bit and the code are ignored, and no further command is issued.
- R10: `arr_abort_i` while `arr_busy_i` is high during a running operation clears start and sets the error flag. An abort while busy is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| reg_we_i | input | 1 | CPU register write strobe |
| reg_wdata_i | input | 16 | CPU write data |
| reg_rdata_o | output | 16 | Register read value |
| prog_mode_i | input | 1 | External programming mode; bulk erase is allowed only while this is high |
| cmd_start_o | output | 1 | One-cycle launch strobe to the array |
| cmd_op_o | output | 2 | Decoded operation, held while the operation runs |
| arr_busy_i | input | 1 | Array is executing an operation |
| arr_done_i | input | 1 | Array completion pulse |
| arr_abort_i | input | 1 | Array abnormal termination |

## Verification
The bench targets the corners where only one of the three legality inputs is wrong: a valid code with the wrong mode, bulk erase outside programming mode, and enable clear. A decoder that checks the code alone would launch a command in these cases instead of flagging an error. During a running operation, the bench writes inverted fields with bit 15 set and then bit 15 clear. A design that fails to freeze the register would show changed fields, a second strobe or an early clear. The bench sends aborts with busy low and with busy high, and it sends a fresh valid start after an error. These catch an abort that ignores busy and an error flag that never clears. A power-on reset in the middle of an operation checks that all state returns to zero.

// File: rtl/flashctl_pkg.sv
// Package: shared field positions, operation encodings and types for the
// flash program/erase control register.
package flashctl_pkg;
    localparam int REG_W     = 16;
    localparam int CODE_W    = 4;
    localparam int OP_W      = 2;
    localparam int START_BIT = 15;
    localparam int WEN_BIT   = 14;
    localparam int ERR_BIT   = 13;
    localparam int MODE_BIT  = 6;
    localparam int CODE_LSB  = 0;

    localparam logic [CODE_W-1:0] CODE_ROW  = 4'b0001;
    localparam logic [CODE_W-1:0] CODE_PAGE = 4'b0010;
    localparam logic [CODE_W-1:0] CODE_WORD = 4'b0011;
    localparam logic [CODE_W-1:0] CODE_BULK = 4'b1111;

    localparam logic [OP_W-1:0] OP_WORD = 2'd0;
    localparam logic [OP_W-1:0] OP_ROW  = 2'd1;
    localparam logic [OP_W-1:0] OP_PAGE = 2'd2;
    localparam logic [OP_W-1:0] OP_BULK = 2'd3;

    typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_CHECK = 2'd1, PH_RUN = 2'd2} phase_e;

    typedef struct packed {
        logic              start;
        logic              wen;
        logic              err;
        logic              mode;
        logic [CODE_W-1:0] code;
    } ctl_fields_t;

    // Place the implemented fields into the 16-bit read image.
    function automatic logic [REG_W-1:0] pack_fields(input ctl_fields_t f);
        logic [REG_W-1:0] r;
        r = '0;
        r[START_BIT] = f.start;
        r[WEN_BIT]   = f.wen;
        r[ERR_BIT]   = f.err;
        r[MODE_BIT]  = f.mode;
        r[CODE_LSB +: CODE_W] = f.code;
        return r;
    endfunction
endpackage

// File: rtl/flashctl_decode.sv
// Module: flashctl_decode
// Maps the operation code, the erase-mode bit and the programming-mode input
// to a legal flag and a decoded operation. Purely combinational.
// Assumes: exactly one table entry can match at a time.
module flashctl_decode
    import flashctl_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              mode_i,
    input  logic              prog_mode_i,
    output logic              legal_o,
    output logic [OP_W-1:0]   op_o
);
    localparam logic [CODE_W-1:0] ENT_CODE [N_ENT] = '{CODE_WORD, CODE_ROW, CODE_PAGE, CODE_BULK};
    localparam logic              ENT_MODE [N_ENT] = '{1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic              ENT_PM   [N_ENT] = '{1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic [OP_W-1:0]   ENT_OP   [N_ENT] = '{OP_WORD, OP_ROW, OP_PAGE, OP_BULK};

    logic [N_ENT-1:0] hit;

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        assign hit[i] = (code_i == ENT_CODE[i]) && (mode_i == ENT_MODE[i])
                        && (prog_mode_i || !ENT_PM[i]);
    end

    // Merge the matching entry into the legal flag and operation value.
    always_comb begin
        op_o = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit[i]) op_o = op_o | ENT_OP[i];
        end
    end

    assign legal_o = |hit;
endmodule

// File: rtl/flashctl_seq.sv
// Module: flashctl_seq
// Sequences one request: a check cycle, then either rejection or launch and
// a run phase that ends on the array's done or abort.
// Assumes: start_req_i only arrives while idle; synchronous active-low reset.
module flashctl_seq
    import flashctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_req_i,
    input  logic            wen_i,
    input  logic            legal_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            arr_busy_i,
    input  logic            arr_done_i,
    input  logic            arr_abort_i,
    output logic            cmd_start_o,
    output logic [OP_W-1:0] cmd_op_o,
    output logic            accept_o,
    output logic            reject_o,
    output logic            end_ok_o,
    output logic            end_abort_o
);
    phase_e phase_q;

    // Classify the current cycle's outcome from the phase and array inputs.
    always_comb begin
        accept_o    = (phase_q == PH_CHECK) && wen_i && legal_i;
        reject_o    = (phase_q == PH_CHECK) && !(wen_i && legal_i);
        end_abort_o = (phase_q == PH_RUN) && arr_abort_i && arr_busy_i;
        end_ok_o    = (phase_q == PH_RUN) && arr_done_i && !end_abort_o;
    end

    // Advance the phase and drive the command strobe and held operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            cmd_start_o <= 1'b0;
            cmd_op_o    <= '0;
        end else begin
            cmd_start_o <= 1'b0;
            case (phase_q)
                PH_IDLE: if (start_req_i) phase_q <= PH_CHECK;
                PH_CHECK: begin
                    if (accept_o) begin
                        phase_q     <= PH_RUN;
                        cmd_start_o <= 1'b1;
                        cmd_op_o    <= op_i;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
                PH_RUN: begin
                    if (end_abort_o || end_ok_o) begin
                        phase_q  <= PH_IDLE;
                        cmd_op_o <= '0;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R7
    cmd_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_o |=> !cmd_start_o);

    // R5
    cmd_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_o |-> wen_i);
endmodule

// File: rtl/flashctl_csr.sv
// Module: flashctl_csr
// Holds the register fields and forms the read image. Software may set start
// and load the configuration only while idle; the sequencer clears start and
// sets or clears the error flag.
// Assumes: end events only occur while start is 1; por_n is the only reset.
module flashctl_csr
    import flashctl_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             accept_i,
    input  logic             reject_i,
    input  logic             end_ok_i,
    input  logic             end_abort_i,
    output ctl_fields_t      fields_o,
    output logic             start_req_o,
    output logic [REG_W-1:0] rdata_o
);
    ctl_fields_t f_q;
    logic        end_op;
    logic        set_err;

    assign end_op      = reject_i | end_ok_i | end_abort_i;
    assign set_err     = reject_i | end_abort_i;
    assign start_req_o = we_i && !f_q.start && wdata_i[START_BIT];

    // Update the fields from software writes and sequencer events.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            f_q <= '0;
        end else begin
            if (we_i && !f_q.start) begin
                f_q.wen  <= wdata_i[WEN_BIT];
                f_q.mode <= wdata_i[MODE_BIT];
                f_q.code <= wdata_i[CODE_LSB +: CODE_W];
                if (wdata_i[START_BIT]) f_q.start <= 1'b1;
            end
            if (set_err)       f_q.err <= 1'b1;
            else if (accept_i) f_q.err <= 1'b0;
            if (end_op)        f_q.start <= 1'b0;
        end
    end

    assign fields_o = f_q;
    assign rdata_o  = pack_fields(f_q);

    // R8
    start_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        f_q.start && !end_op |=> f_q.start);

    // R9
    frozen_cfg_chk: assert property (@(posedge clk) disable iff (!por_n)
        f_q.start |=> $stable(f_q.wen) && $stable(f_q.mode) && $stable(f_q.code));

    // R6
    reject_err_chk: assert property (@(posedge clk) disable iff (!por_n)
        reject_i |=> f_q.err && !f_q.start);

    // R10
    abort_err_chk: assert property (@(posedge clk) disable iff (!por_n)
        end_abort_i |=> f_q.err && !f_q.start);
endmodule

// File: rtl/flash_nvm_ctl.sv
// Module: flash_nvm_ctl
// Top of the flash program/erase control register: connects the field
// register, the legality decoder and the request sequencer.
// Assumes: array done/abort inputs are synchronous to clk.
module flash_nvm_ctl
    import flashctl_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             reg_we_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    input  logic             prog_mode_i,
    output logic             cmd_start_o,
    output logic [OP_W-1:0]  cmd_op_o,
    input  logic             arr_busy_i,
    input  logic             arr_done_i,
    input  logic             arr_abort_i
);
    ctl_fields_t     fields;
    logic            start_req;
    logic            legal;
    logic [OP_W-1:0] op;
    logic            accept, reject, end_ok, end_abort;

    flashctl_csr u_csr (
        .clk         (clk),
        .por_n       (por_n),
        .we_i        (reg_we_i),
        .wdata_i     (reg_wdata_i),
        .accept_i    (accept),
        .reject_i    (reject),
        .end_ok_i    (end_ok),
        .end_abort_i (end_abort),
        .fields_o    (fields),
        .start_req_o (start_req),
        .rdata_o     (reg_rdata_o)
    );

    flashctl_decode #(.N_ENT(4)) u_dec (
        .code_i      (fields.code),
        .mode_i      (fields.mode),
        .prog_mode_i (prog_mode_i),
        .legal_o     (legal),
        .op_o        (op)
    );

    flashctl_seq u_seq (
        .clk         (clk),
        .rst_n       (por_n),
        .start_req_i (start_req),
        .wen_i       (fields.wen),
        .legal_i     (legal),
        .op_i        (op),
        .arr_busy_i  (arr_busy_i),
        .arr_done_i  (arr_done_i),
        .arr_abort_i (arr_abort_i),
        .cmd_start_o (cmd_start_o),
        .cmd_op_o    (cmd_op_o),
        .accept_o    (accept),
        .reject_o    (reject),
        .end_ok_o    (end_ok),
        .end_abort_o (end_abort)
    );

    // R4
    bulk_needs_pm_chk: assert property (@(posedge clk) disable iff (!por_n)
        cmd_start_o && (cmd_op_o == OP_BULK) |-> $past(prog_mode_i));
endmodule

// File: tb/flash_nvm_ctl_bench.sv
// Bench: directed corners plus seeded random requests against a model.
module flash_nvm_ctl_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        prog_mode = 1'b0;
    logic        cmd_start;
    logic [1:0]  cmd_op;
    logic        arr_busy = 1'b0, arr_done = 1'b0, arr_abort = 1'b0;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    flash_nvm_ctl u_flash_nvm_ctl (
        .clk(clk), .por_n(por_n), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .prog_mode_i(prog_mode), .cmd_start_o(cmd_start),
        .cmd_op_o(cmd_op), .arr_busy_i(arr_busy), .arr_done_i(arr_done),
        .arr_abort_i(arr_abort)
    );

    function automatic logic [15:0] pk(input logic st, input logic w, input logic e,
                                       input logic m, input logic [3:0] c);
        return {st, w, e, 6'b0, m, 2'b0, c};
    endfunction

    function automatic logic legal_m(input logic [3:0] c, input logic m, input logic pm);
        case (c)
            4'hF: return m && pm;
            4'h2: return m;
            4'h3: return !m;
            4'h1: return !m;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [1:0] op_m(input logic [3:0] c);
        case (c)
            4'hF: return 2'd3;
            4'h2: return 2'd2;
            4'h1: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // ending: 0 done, 1 abort while busy, 2 idle abort probe then done
    task automatic run_op(input logic w, input logic m, input logic [3:0] c,
                          input logic pm, input int ending);
        logic  ok;
        string rq;
        ok = w && legal_m(c, m, pm);
        rq = !w ? "R5" : ((c == 4'hF && m && !pm) ? "R4" : "R6");
        prog_mode = pm;
        wr(pk(1'b1, w, 1'b0, m, c));
        chk("R5 start visible in check cycle", {15'b0, reg_rdata[15]}, 16'd1);
        @(negedge clk);
        chk(ok ? "R7 strobe" : rq, {15'b0, cmd_start}, {15'b0, ok});
        if (ok) begin
            chk("R3 cmd_op", {14'b0, cmd_op}, {14'b0, op_m(c)});
            chk("R7 err cleared", reg_rdata, pk(1'b1, 1'b1, 1'b0, m, c));
            @(negedge clk);
            chk("R7 single cycle", {15'b0, cmd_start}, 16'd0);
            if (ending == 2) begin
                arr_abort = 1'b1;
                @(negedge clk);
                arr_abort = 1'b0;
                chk("R10 abort without busy", reg_rdata, pk(1'b1, 1'b1, 1'b0, m, c));
            end
            arr_busy = 1'b1;
            wr({1'b1, 1'b0, 1'b1, 6'h3F, ~m, 2'b11, ~c});
            chk("R9 frozen", reg_rdata, pk(1'b1, 1'b1, 1'b0, m, c));
            chk("R9 no restart", {15'b0, cmd_start}, 16'd0);
            wr(16'h0000);
            chk("R8 sw clear ignored", reg_rdata, pk(1'b1, 1'b1, 1'b0, m, c));
            repeat ($urandom % 4) @(negedge clk);
            if (ending == 1) begin
                arr_abort = 1'b1;
                @(negedge clk);
                arr_abort = 1'b0;
                arr_busy = 1'b0;
                chk("R10 abort", reg_rdata, pk(1'b0, 1'b1, 1'b1, m, c));
            end else begin
                arr_busy = 1'b0;
                arr_done = 1'b1;
                @(negedge clk);
                arr_done = 1'b0;
                chk("R8 done clears", reg_rdata, pk(1'b0, 1'b1, 1'b0, m, c));
            end
        end else begin
            chk(rq, reg_rdata, pk(1'b0, w, 1'b1, m, c));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] c;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk("R2 reset value", reg_rdata, 16'h0000);
        chk("R2 reset strobe", {15'b0, cmd_start}, 16'd0);
        // R1 layout and unimplemented bits
        wr(16'h7FFF);
        chk("R1 layout", reg_rdata, 16'h404F);
        wr(16'h2000);
        chk("R1 err not writable", reg_rdata, 16'h0000);
        // R3 each legal pair
        run_op(1'b1, 1'b0, 4'h3, 1'b0, 0);
        run_op(1'b1, 1'b0, 4'h1, 1'b0, 0);
        run_op(1'b1, 1'b1, 4'h2, 1'b0, 2);
        run_op(1'b1, 1'b1, 4'hF, 1'b1, 0);
        // R4, R5, R6 rejections
        run_op(1'b1, 1'b1, 4'hF, 1'b0, 0);
        run_op(1'b0, 1'b0, 4'h3, 1'b0, 0);
        run_op(1'b1, 1'b0, 4'h2, 1'b0, 0);
        run_op(1'b1, 1'b1, 4'h3, 1'b0, 0);
        run_op(1'b1, 1'b0, 4'h5, 1'b1, 0);
        wr(16'h0000);
        chk("R1 err sticky", reg_rdata, 16'h2000);
        // R7 fresh valid start clears error, R10 abort with busy
        run_op(1'b1, 1'b0, 4'h1, 1'b0, 1);
        run_op(1'b1, 1'b0, 4'h3, 1'b0, 0);
        // R2 power-on reset in the middle of an operation
        prog_mode = 1'b0;
        wr(pk(1'b1, 1'b1, 1'b0, 1'b1, 4'h2));
        @(negedge clk);
        arr_busy = 1'b1;
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        arr_busy = 1'b0;
        chk("R2 reset mid-run", reg_rdata, 16'h0000);
        chk("R2 reset mid-run cmd_op", {14'b0, cmd_op}, 16'd0);
        // random mix
        for (int i = 0; i < 80; i++) begin
            if ($urandom % 2 == 0) begin
                case ($urandom % 4)
                    0: c = 4'h1;
                    1: c = 4'h2;
                    2: c = 4'h3;
                    default: c = 4'hF;
                endcase
            end else begin
                c = 4'($urandom);
            end
            run_op(($urandom % 5) != 0, 1'($urandom), c, 1'($urandom), int'($urandom % 3));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule